// File: doc/BRIEF.md
# Fixed-Width Radix-4 Booth Multiplier with Data-Dependent Bias

This block multiplies two signed WIDTH-bit operands and returns only the upper WIDTH bits of the product, which is the form a fixed-point datapath such as a filter tap or a transform butterfly wants. The multiplier operand is recoded into radix-4 digits, so only WIDTH/2 partial-product rows are formed. Every partial-product bit that lands below column WIDTH is dropped. The sign handling of each row is reduced to a single inverted sign bit plus one folded constant, so no sign bits are replicated across the array.

Dropping the low columns throws away the carries they would have sent upward. The block estimates that lost carry from the one column just below the kept region, called the guard column here. Each row places exactly one bit in that column. The estimate depends on how many of those bits are set, with a threshold at "all set". It is added to the kept sum at the weight of the output LSB. The result has a much smaller error than plain truncation, and the extra logic is only a bit count and one AND-reduction.

The block is purely combinational, with no clock, reset or handshake.

Top module: `fxw_booth_mul`

## Requirements
- R1: Row i (i = 0 .. WIDTH/2-1) takes the multiplier bits (b[2i+1], b[2i], b[2i-1]), where b[-1] = 0. Its digit is d = b[2i] + b[2i-1] - 2*b[2i+1], a value in {-2,-1,0,1,2}. Exactly one of the "select A" and "select 2A" controls is set when d is nonzero, and neither is set when d is zero.
- R2: Row i holds |d|*A as a (WIDTH+1)-bit two's-complement field with weight 4^i. For a negative d the field is bitwise inverted, and the +1 that completes the negation sits at column 2i. That +1 lies in the discarded region, so it is never summed. A zero digit gives an all-zero field with no negation.
- R3: The guard bit of row i is bit WIDTH-1-2i of its field, so that it falls in product column WIDTH-1. When A = 0 and the digit is not negative, every guard bit is 0.
- R4: Let t be the number of set guard bits. The bias is t-1 when t < WIDTH/2, and WIDTH/2 when all guard bits are set. Both the all-clear case (bias -1) and the all-set case occur over the full operand space.
- R5: The output equals (A*B - L)/2^WIDTH + bias as a signed WIDTH-bit value. L is the sum, over rows, of 4^i times the sum of the row's field bits below column WIDTH and its negation +1.
- R6: The output is a combinational function of the operands. It is valid within the same clock period in which the operands change.
- R7: Over all 2^(2*WIDTH) operand pairs, the largest |A*B - out*2^WIDTH| is strictly smaller than that of the same array with the bias forced to 0.
- R8: Over all operand pairs, the mean of |A*B - out*2^WIDTH| is strictly smaller than that of the same array with the bias forced to 0.
- R9: The extreme operands -2^(WIDTH-1) and 2^(WIDTH-1)-1, in any pairing, produce the R5 value with no wrap-around. For WIDTH = 8: (-128)*(-128) gives 63, 127*127 gives 63, and 127*(-128) gives -65.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Signed multiplicand |
| op_b | input | WIDTH | Signed multiplier, recoded into radix-4 digits |
| prod_hi | output | WIDTH | Signed upper half of the product, bias included |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between the operands and prod_hi. The bench therefore changes the operands on a falling clock edge and reads prod_hi one nanosecond later, still inside the same period and away from any rising edge. It makes the same-period read for the fixed vector table, for the directed corner cases and for each step of the exhaustive sweep. The error statistics of R7 and R8 are gathered from those same-period reads and judged only after the sweep has finished.

// File: rtl/fxw_pkg.sv
package fxw_pkg;

  // Radix-4 digit controls for one partial-product row.
  typedef struct packed {
    logic neg;   // digit is negative: invert field, +1 at row LSB
    logic two;   // magnitude 2: shifted multiplicand
    logic one;   // magnitude 1: plain multiplicand
  } bsel_t;

  // Folded sign constant: each row's sign bit s at column w+2i is
  // replaced by ~s, which is off by +2^(w+2i); subtract all of them.
  function automatic logic [63:0] sign_gen_const(input int w);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < w / 2; i++) begin
      acc = acc + (64'd1 << (w + 2 * i));
    end
    return (~acc) + 64'd1;
  endfunction

endpackage

// File: rtl/fxw_booth_enc.sv
module fxw_booth_enc
  import fxw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]         mplr,
  output bsel_t [WIDTH/2-1:0]      sel
);

  localparam int NROW = WIDTH / 2;

  // Multiplier with the implicit zero below its LSB.
  logic [WIDTH:0] mx;
  assign mx = {mplr, 1'b0};

  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      logic [2:0] trip;
      trip       = mx[2*r +: 3];
      sel[r].one = trip[1] ^ trip[0];
      sel[r].two = (trip == 3'b011) || (trip == 3'b100);
      sel[r].neg = trip[2] & ~(trip[1] & trip[0]);
    end
  end

endmodule

// File: rtl/fxw_pp_row.sv
module fxw_pp_row
  import fxw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] mcnd,
  input  bsel_t            sel,
  output logic [WIDTH:0]   bits
);

  logic [WIDTH:0] mag;

  always_comb begin
    if (sel.two) begin
      mag = {mcnd, 1'b0};
    end else if (sel.one) begin
      mag = {mcnd[WIDTH-1], mcnd};
    end else begin
      mag = '0;
    end
    bits = mag ^ {(WIDTH+1){sel.neg}};
  end

endmodule

// File: rtl/fxw_bias.sv
module fxw_bias #(
  parameter int NROW = 4,
  parameter int CW   = $clog2(NROW + 1) + 1
) (
  input  logic [NROW-1:0]        guard,
  output logic signed [CW-1:0]   bias
);

  logic [CW-1:0] ones;
  logic          all_set;

  always_comb begin
    ones = '0;
    for (int k = 0; k < NROW; k++) begin
      ones = ones + CW'(guard[k]);
    end
  end

  assign all_set = &guard;

  // t-1 below the threshold; at t = NROW the -1 is cancelled.
  assign bias = $signed(ones - CW'(1) + CW'(all_set));

endmodule

// File: rtl/fxw_kept_sum.sv
module fxw_kept_sum
  import fxw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH/2-1:0][WIDTH:0] rows,
  output logic [WIDTH-1:0]            kept_hi
);

  localparam int NROW = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;
  localparam logic [63:0] SGC_FULL = sign_gen_const(WIDTH);
  localparam logic [PW-1:0] SGC    = SGC_FULL[PW-1:0];
  localparam logic [PW-1:0] KEEP   = {{WIDTH{1'b1}}, {WIDTH{1'b0}}};

  logic [PW-1:0] acc;
  logic [PW-1:0] term;

  always_comb begin
    acc  = SGC;
    term = '0;
    for (int r = 0; r < NROW; r++) begin
      term = PW'({~rows[r][WIDTH], rows[r][WIDTH-1:0]}) << (2 * r);
      acc  = acc + (term & KEEP);
    end
  end

  assign kept_hi = acc[PW-1:WIDTH];

endmodule

// File: rtl/fxw_booth_mul.sv
module fxw_booth_mul
  import fxw_pkg::*;
#(
  parameter int WIDTH = 8   // even, at least 4
) (
  input  logic signed [WIDTH-1:0] op_a,
  input  logic signed [WIDTH-1:0] op_b,
  output logic signed [WIDTH-1:0] prod_hi
);

  localparam int NROW = WIDTH / 2;
  localparam int CW   = $clog2(NROW + 1) + 1;

  bsel_t [NROW-1:0]           sel;
  logic  [NROW-1:0][WIDTH:0]  rows;
  logic  [NROW-1:0]           guard;
  logic  signed [CW-1:0]      bias;
  logic  [WIDTH-1:0]          kept_hi;

  fxw_booth_enc #(.WIDTH(WIDTH)) u_enc (
    .mplr (op_b),
    .sel  (sel)
  );

  for (genvar g = 0; g < NROW; g++) begin : g_row
    fxw_pp_row #(.WIDTH(WIDTH)) u_row (
      .mcnd (op_a),
      .sel  (sel[g]),
      .bits (rows[g])
    );
    // Bit of this row that lands in product column WIDTH-1.
    assign guard[g] = rows[g][WIDTH-1-2*g];
  end

  fxw_bias #(.NROW(NROW), .CW(CW)) u_bias (
    .guard (guard),
    .bias  (bias)
  );

  fxw_kept_sum #(.WIDTH(WIDTH)) u_sum (
    .rows    (rows),
    .kept_hi (kept_hi)
  );

  assign prod_hi = $signed(kept_hi + {{(WIDTH-CW){bias[CW-1]}}, bias});

endmodule

// File: rtl/fxw_booth_mul_chk.sv
module fxw_booth_mul_chk
  import fxw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic signed [WIDTH-1:0]                   op_a,
  input bsel_t [WIDTH/2-1:0]                       sel,
  input logic [WIDTH/2-1:0][WIDTH:0]               rows,
  input logic [WIDTH/2-1:0]                        guard,
  input logic signed [$clog2(WIDTH/2+1):0]         bias
);

  localparam int NROW = WIDTH / 2;

  always_comb begin
    for (int r = 0; r < NROW; r++) begin
      assert_sel_onehot_R1: assert ($onehot0({sel[r].one, sel[r].two}))
        else $error("R1: both magnitude selects set on row %0d", r);
      if (!sel[r].one && !sel[r].two) begin
        assert_zero_digit_R2: assert (rows[r] == '0 && !sel[r].neg)
          else $error("R2: zero digit produced nonzero row %0d", r);
      end
      if (op_a == '0 && !sel[r].neg) begin
        assert_zero_a_R3: assert (guard[r] == 1'b0)
          else $error("R3: guard bit set with zero multiplicand, row %0d", r);
      end
    end
    assert_bias_range_R4: assert (bias >= -1 && bias <= NROW)
      else $error("R4: bias %0d out of range", bias);
    if (&guard) begin
      assert_bias_full_R4: assert (bias == NROW)
        else $error("R4: all guard bits set but bias %0d", bias);
    end
    if (guard == '0) begin
      assert_bias_empty_R4: assert (bias == -1)
        else $error("R4: no guard bits set but bias %0d", bias);
    end
  end

endmodule

bind fxw_booth_mul fxw_booth_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a  (op_a),
  .sel   (sel),
  .rows  (rows),
  .guard (guard),
  .bias  (bias)
);

// File: tb/sim_fxw_booth_mul.sv
module sim_fxw_booth_mul;

  localparam int W  = 8;
  localparam int NR = W / 2;
  localparam int NV = 8;

  // {op_a, op_b, expected prod_hi}
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'hFF},
    {8'h00, 8'hFF, 8'hFF},
    {8'h01, 8'h01, 8'hFF},
    {8'h80, 8'h80, 8'h3F},
    {8'h7F, 8'h7F, 8'h3F},
    {8'hFF, 8'hFF, 8'hFF},
    {8'h40, 8'h02, 8'hFF},
    {8'h7F, 8'h80, 8'hBF}
  };

  logic clk;
  logic rst_n;
  logic signed [W-1:0] a;
  logic signed [W-1:0] b;
  logic signed [W-1:0] prod;

  int  n_vec;
  int  n_bad;
  bit  done;

  fxw_booth_mul #(.WIDTH(W)) u0 (
    .op_a    (a),
    .op_b    (b),
    .prod_hi (prod)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input longint got, input longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, got, exp);
    end
  endtask

  // Independent arithmetic model of the requirements.
  task automatic model(input int av, input int bv, output int out_c,
                       output int out_t, output int t_cnt);
    int lo;
    int fmask;
    lo    = 0;
    t_cnt = 0;
    fmask = (1 << (W + 1)) - 1;
    for (int i = 0; i < NR; i++) begin
      int bm;
      int b0;
      int b1;
      int d;
      int fld;
      int ng;
      bm = (i == 0) ? 0 : ((bv >> (2 * i - 1)) & 1);
      b0 = (bv >> (2 * i)) & 1;
      b1 = (bv >> (2 * i + 1)) & 1;
      d  = b0 + bm - 2 * b1;
      if (d < 0) begin
        fld = (d * av - 1) & fmask;
        ng  = 1;
      end else begin
        fld = (d * av) & fmask;
        ng  = 0;
      end
      t_cnt += (fld >> (W - 1 - 2 * i)) & 1;
      lo    += ((fld & ((1 << (W - 2 * i)) - 1)) + ng) << (2 * i);
    end
    out_t = (av * bv - lo) / (1 << W);
    out_c = out_t + ((t_cnt == NR) ? NR : t_cnt - 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int     oc;
    int     ot;
    int     tc;
    int     max_c;
    int     max_t;
    longint sum_c;
    longint sum_t;
    int     seen0;
    int     seen4;
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    a     = '0;
    b     = '0;
    repeat (2) @(negedge clk);
    #1;
    // Initial state with zero operands: no guard bit set, bias -1 (R4).
    check("R4 zero operands", prod, -1);
    rst_n = 1'b1;

    // Output follows an operand change inside the same period (R6).
    @(negedge clk);
    a = 8'sd100;
    b = 8'sd50;
    #1;
    model(100, 50, oc, ot, tc);
    check("R6 same-period result", prod, oc);

    // Vector table (R5, extremes for R9).
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      a = VEC[v][23:16];
      b = VEC[v][15:8];
      #1;
      check((v == 3 || v == 4 || v == 7) ? "R9 extreme table" : "R5 table",
            prod, $signed(VEC[v][7:0]));
    end

    // Directed: multiplicand zero, multiplier all ones -> -1 (R2 negate with A=0).
    @(negedge clk);
    a = 8'sd0;
    b = -8'sd1;
    #1;
    check("R2 negated zero row", prod, -1);

    // Exhaustive sweep (R1, R3, R5) with error statistics (R7, R8).
    max_c = 0;
    max_t = 0;
    sum_c = 0;
    sum_t = 0;
    seen0 = 0;
    seen4 = 0;
    for (int ai = -128; ai < 128; ai++) begin
      for (int bi = -128; bi < 128; bi++) begin
        int ec;
        int et;
        @(negedge clk);
        a = W'(ai);
        b = W'(bi);
        #1;
        model(ai, bi, oc, ot, tc);
        check("R5 sweep", prod, oc);
        if (tc == 0) seen0++;
        if (tc == NR) seen4++;
        ec = ai * bi - int'(prod) * (1 << W);
        et = ai * bi - ot * (1 << W);
        if (ec < 0) ec = -ec;
        if (et < 0) et = -et;
        if (ec > max_c) max_c = ec;
        if (et > max_t) max_t = et;
        sum_c += ec;
        sum_t += et;
      end
    end

    check("R4 all-clear guard case seen", longint'(seen0 > 0), 1);
    check("R4 all-set guard case seen", longint'(seen4 > 0), 1);
    check("R7 max error below truncation", longint'(max_c < max_t), 1);
    if (max_c >= max_t)
      $display("  R7 detail: max_bias=%0d max_trunc=%0d", max_c, max_t);
    check("R8 mean error below truncation", longint'(sum_c < sum_t), 1);
    if (sum_c >= sum_t)
      $display("  R8 detail: sum_bias=%0d sum_trunc=%0d", sum_c, sum_t);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule